// File: doc/BRIEF.md
# Single-Bit Weighted Constant Adder

This block forms a signed weighted sum. Each weight is a fixed signed integer chosen when the block is built, and each one is gated by its own single-bit input. The result is the sum of every weight whose bit is 1. Because each input is one bit, a product reduces to a conditional add of a constant, so the block needs no multiplier. It suits bit-serial filters, distributed-arithmetic lookups and correlators against a fixed code.

The build can set from one to eight inputs, the weight width, and whether the input bits pass through a register first. It can also make the enable input and the synchronous clear input active or leave them unused. The output always has a register. It is wide enough that no mix of input bits can overflow it.

Top module: `bitmask_const_sum`

## Requirements
- R1: Without the input register (IN_REG=0), `sum_out` equals the signed sum of `COEFS[i]` over every i where `bits_in[i]` was 1, one clock edge after the bits were sampled. Weight i sits at `COEFS[i*CW +: CW]`, two's complement.
- R2: With the input register (IN_REG=1), the same sum appears two clock edges after the bits were sampled. A new pattern is accepted on every cycle.
- R3: `sum_out` is signed and CW+ceil(log2(N_IN)) bits wide. It holds the exact sum even when every weight is the most negative CW-bit value.
- R4: With USE_EN=1, while `en` is 0 and `clr` is 0, every register holds its value. `sum_out` stays stable and changes to the input bits are not captured.
- R5: With USE_CLR=1, `clr`=1 zeroes every register at the next edge, the input register included. `sum_out` reads 0 after that edge and stays 0 until nonzero bits are captured again.
- R6: When `clr` and `en` are both active, clear wins. `clr`=1 also clears the registers while `en`=0.
- R7: While `rst_n` is 0, `sum_out` is 0 whatever the inputs are.
- R8: With USE_EN=0 the `en` input has no effect, and with USE_CLR=0 the `clr` input has no effect. The block then behaves as if enable were always 1 and clear always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; used only when USE_EN=1 |
| clr | input | 1 | Synchronous clear; used only when USE_CLR=1 |
| bits_in | input | N_IN | One select bit per weight |
| sum_out | output | CW+ceil(log2(N_IN)) | Registered signed weighted sum |

## Verification
The sum is due one edge after a pattern is sampled without the input register, and two edges after with it. The bench streams a new pattern on every cycle. At each falling edge it compares the output with the sum it computed for the pattern driven one or two cycles earlier, so it checks the pipeline timing as well as the arithmetic. For enable and clear, it checks the output one edge and two edges after the control changes. This shows whether the input register held its value or was cleared before the new bits come through.

// File: rtl/bitmask_const_sum.sv
module bitmask_const_sum #(
  parameter int N_IN    = 4,
  parameter int CW      = 8,
  parameter logic [N_IN*CW-1:0] COEFS = '0,
  parameter bit IN_REG  = 1'b1,
  parameter bit USE_EN  = 1'b1,
  parameter bit USE_CLR = 1'b1,
  localparam int OW = CW + $clog2(N_IN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic [N_IN-1:0]      bits_in,
  output logic signed [OW-1:0] sum_out
);

  logic            en_eff, clr_eff;
  logic [N_IN-1:0] bits_q;
  logic signed [OW-1:0] acc;

  assign en_eff  = USE_EN  ? en  : 1'b1;
  assign clr_eff = USE_CLR ? clr : 1'b0;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bits_q <= '0;
        else if (clr_eff) bits_q <= '0;
        else if (en_eff)  bits_q <= bits_in;
      end
    end else begin : g_in_wire
      assign bits_q = bits_in;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_IN; i++)
      if (bits_q[i]) acc = acc + OW'($signed(COEFS[i*CW +: CW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_out <= '0;
    else if (clr_eff) sum_out <= '0;
    else if (en_eff)  sum_out <= acc;
  end

endmodule

// File: rtl/bitmask_const_sum_chk.sv
module bitmask_const_sum_chk #(
  parameter int N_IN    = 4,
  parameter int CW      = 8,
  parameter logic [N_IN*CW-1:0] COEFS = '0,
  parameter bit IN_REG  = 1'b1,
  parameter bit USE_EN  = 1'b1,
  parameter bit USE_CLR = 1'b1,
  localparam int OW = CW + $clog2(N_IN)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 clr,
  input logic [N_IN-1:0]      bits_in,
  input logic signed [OW-1:0] sum_out
);

  localparam longint LO = -(longint'(N_IN) * (longint'(1) <<< (CW-1)));
  localparam longint HI = longint'(N_IN) * ((longint'(1) <<< (CW-1)) - 1);

  function automatic longint wsum(input logic [N_IN-1:0] b);
    longint s = 0;
    for (int i = 0; i < N_IN; i++)
      if (b[i]) s += longint'($signed(COEFS[i*CW +: CW]));
    return s;
  endfunction

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(sum_out) >= LO) && (longint'(sum_out) <= HI));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_EN && !en && !(USE_CLR && clr)) |=> $stable(sum_out));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_CLR && clr) |=> (sum_out == '0));

  p_clr_over_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_CLR && clr && USE_EN && en) |=> (sum_out == '0));

  p_no_en_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!USE_EN && !USE_CLR && !en && !IN_REG) |=> (longint'(sum_out) == wsum($past(bits_in))));

  p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!IN_REG && (!USE_EN || en) && !(USE_CLR && clr)) |=> (longint'(sum_out) == wsum($past(bits_in))));

  always @(negedge clk)
    if (!rst_n) p_reset_zero_r7: assert (sum_out == '0);

endmodule

bind bitmask_const_sum bitmask_const_sum_chk #(
  .N_IN(N_IN), .CW(CW), .COEFS(COEFS),
  .IN_REG(IN_REG), .USE_EN(USE_EN), .USE_CLR(USE_CLR)
) u_chk (.*);

// File: tb/bitmask_const_sum_bench.sv
module bitmask_const_sum_bench;
  localparam int NA = 4, CWA = 6, OWA = CWA + $clog2(NA);
  localparam int NB = 3, CWB = 5, OWB = CWB + $clog2(NB);
  localparam int CA [NA] = '{-32, 31, -7, 13};
  localparam int CB [NB] = '{-16, -16, -16};
  localparam logic [NA*CWA-1:0] VA = {CWA'(13), CWA'(-7), CWA'(31), CWA'(-32)};
  localparam logic [NB*CWB-1:0] VB = {CWB'(-16), CWB'(-16), CWB'(-16)};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_a = 1'b1, clr_a = 1'b0, en_b = 1'b0, clr_b = 1'b1;
  logic [NA-1:0] bits_a = '0;
  logic [NB-1:0] bits_b = '0;
  logic signed [OWA-1:0] sum_a;
  logic signed [OWB-1:0] sum_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitmask_const_sum #(.N_IN(NA), .CW(CWA), .COEFS(VA), .IN_REG(1'b1),
    .USE_EN(1'b1), .USE_CLR(1'b1)) u_bitmask_const_sum (
    .clk(clk), .rst_n(rst_n), .en(en_a), .clr(clr_a), .bits_in(bits_a), .sum_out(sum_a));

  bitmask_const_sum #(.N_IN(NB), .CW(CWB), .COEFS(VB), .IN_REG(1'b0),
    .USE_EN(1'b0), .USE_CLR(1'b0)) u_bitmask_const_sum_b (
    .clk(clk), .rst_n(rst_n), .en(en_b), .clr(clr_b), .bits_in(bits_b), .sum_out(sum_b));

  function automatic int exp_a(input logic [NA-1:0] b);
    int s = 0;
    for (int i = 0; i < NA; i++) if (b[i]) s += CA[i];
    return s;
  endfunction

  function automatic int exp_b(input logic [NB-1:0] b);
    int s = 0;
    for (int i = 0; i < NB; i++) if (b[i]) s += CB[i];
    return s;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NA-1:0] hist_a [2];
    logic [NB-1:0] prev_b;
    bits_a = '1; bits_b = '1;
    @(negedge clk); @(negedge clk);
    check("R7 reset A", int'(sum_a), 0);
    check("R7 reset B", int'(sum_b), 0);
    rst_n = 1'b1;
    bits_a = '0; bits_b = '0;
    step(); step();

    // R2: stream all 16 patterns, one per cycle, two-cycle latency
    for (int j = 0; j < 18; j++) begin
      if (j >= 2) check("R2 stream", int'(sum_a), exp_a(hist_a[j % 2]));
      hist_a[j % 2] = NA'(j % 16);
      bits_a = NA'(j % 16);
      step();
    end

    // R1 R3 R8: config B, en=0 and clr=1 held but unused
    en_b = 1'b0; clr_b = 1'b1;
    prev_b = '0;
    for (int j = 0; j < 9; j++) begin
      bits_b = NB'(j % 8);
      step();
      check("R1 R8 one-cycle B", int'(sum_b), exp_b(NB'(j % 8)));
      prev_b = bits_b;
    end
    bits_b = '1; step();
    check("R3 all most-negative", int'(sum_b), -48);

    // R4: enable low holds output and input register
    bits_a = 4'b1010; step(); step();
    check("R4 setup", int'(sum_a), 44);
    en_a = 1'b0; bits_a = 4'b0101;
    step(); step(); step();
    check("R4 hold while en=0", int'(sum_a), 44);
    en_a = 1'b1; step();
    check("R4 input reg held", int'(sum_a), 44);
    step();
    check("R4 new value after en", int'(sum_a), -39);

    // R5 R6: clear with en=1, clears input register too
    clr_a = 1'b1; step();
    check("R6 clr over en", int'(sum_a), 0);
    clr_a = 1'b0; step();
    check("R5 input reg cleared", int'(sum_a), 0);
    step();
    check("R5 recover", int'(sum_a), -39);

    // R6: clear while en=0
    en_a = 1'b0; clr_a = 1'b1; step();
    check("R6 clr with en=0", int'(sum_a), 0);
    clr_a = 1'b0; step(); step();
    check("R6 stays zero", int'(sum_a), 0);
    en_a = 1'b1; bits_a = 4'b1111; step(); step();
    check("R2 full set", int'(sum_a), 5);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule